// File: doc/BRIEF.md
# Interrupt Capture Buffer for a Self-Tested Core

This block sits between the interrupt sources of a chip and a processor core that is periodically cut off from the rest of the system while its logic runs a self-test slice. Software turns the buffer on before starting a slice. While the core is isolated, the block records interrupt pulses in one pending bit per line instead of forwarding them. When isolation ends and software has restored the core's context, a release request replays every recorded line to the core as a single-cycle pulse. DMA trigger lines are never captured. They run straight through, so DMA channels keep moving data during the test.

A four-state phase machine tracks the buffer. IDLE means the buffer is off and holds nothing. ARMED means it is on, the core is connected, and nothing is pending. HOLD means it is on and the core is isolated, so capture is active. HELD means isolation has ended or capture was switched off while bits are pending, and the buffer waits for release.

The transitions are named as follows. "enable" moves IDLE to ARMED and "disable" moves ARMED to IDLE. "isolate" enters HOLD from any state whenever the buffer is on and the core is isolated. "reconnect" leaves HOLD for HELD when bits are pending, or for ARMED or IDLE when none are. "replay" leaves HELD for ARMED or IDLE when a release is honoured. "wait" keeps HELD until then.

Top module: `irq_capture_buffer`

## Requirements
- R1: After reset all pending flags are 0, the phase is IDLE, and interrupt lines pass through.
- R2: While the capture enable is low, `irq_to_core` equals `irq_in` in the same cycle, whatever the isolation status, and no pending bit is set.
- R3: While the capture enable is high and the core is not isolated, `irq_to_core` equals `irq_in` in the same cycle and no pending bit is set.
- R4: While the capture enable is high and the core is isolated, `irq_to_core` is all zero, and each line that is high sets its pending bit at the next clock edge.
- R5: Several pulses on one line during isolation merge into one pending bit, which yields a single replay pulse.
- R6: A release honoured in phase HELD drives every pending line high on `irq_to_core` for that one cycle, and all pending bits are clear from the next edge.
- R7: A release is ignored while the core is isolated and in the first cycle after isolation ends (phase HOLD): pending bits stay and nothing is replayed.
- R8: An interrupt pulse in the same cycle as an honoured release is delivered directly on `irq_to_core`, merged with the replay, and is not recorded.
- R9: `dma_trig_out` equals `dma_trig_in` in every cycle, including during isolation.
- R10: `pending_flags` bit i shows the recorded state of interrupt line i.
- R11: Dropping the capture enable during isolation stops capture, so lines pass through, but keeps already recorded bits until a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Interrupt pulses from the sources |
| dma_trig_in | input | NUM_LINES | DMA trigger lines from the sources |
| cap_enable | input | 1 | Software capture enable |
| core_bounded | input | 1 | High while the core is isolated for self-test |
| release_req | input | 1 | Software request to replay recorded interrupts |
| irq_to_core | output | NUM_LINES | Interrupt lines to the core |
| dma_trig_out | output | NUM_LINES | DMA trigger lines to the DMA channels |
| pending_flags | output | NUM_LINES | One recorded-request flag per interrupt line |

## Verification
The bench builds the buffer with NUM_LINES set to 5. This odd width makes bit order visible in the pending flags and gives each scenario distinct line patterns. With five lines the bench can place capture, merging, a direct pulse that lands with a replay, and lines recorded before capture was switched off on separate lines at the same time. Every case is then told apart by bit position.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_HOLD  = 2'd2,
        PH_HELD  = 2'd3
    } ibuf_phase_e;

endpackage

// File: rtl/ibuf_phase_fsm.sv
module ibuf_phase_fsm
    import ibuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_enable,
    input  logic core_bounded,
    input  logic release_req,
    input  logic any_pending,
    output logic capture,
    output logic flush
);

    ibuf_phase_e phase_q;
    ibuf_phase_e phase_d;
    logic        capture_now;

    assign capture_now = cap_enable & core_bounded;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // next phase
    always_comb begin
        phase_d = phase_q;
        if (capture_now) begin
            phase_d = PH_HOLD;                          // isolate
        end else begin
            unique case (phase_q)
                PH_IDLE:  phase_d = cap_enable ? PH_ARMED : PH_IDLE;   // enable
                PH_ARMED: phase_d = cap_enable ? PH_ARMED : PH_IDLE;   // disable
                PH_HOLD: begin                                          // reconnect
                    if (any_pending)     phase_d = PH_HELD;
                    else if (cap_enable) phase_d = PH_ARMED;
                    else                 phase_d = PH_IDLE;
                end
                PH_HELD: begin
                    if (release_req && !core_bounded)               // replay
                        phase_d = cap_enable ? PH_ARMED : PH_IDLE;
                    else
                        phase_d = PH_HELD;                          // wait
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        capture = capture_now;
        flush   = 1'b0;
        unique case (phase_q)
            PH_HELD:  flush = release_req & ~core_bounded;
            PH_IDLE,
            PH_ARMED,
            PH_HOLD:  flush = 1'b0;
            default:  flush = 1'b0;
        endcase
    end

    p_no_flush_in_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD) |-> !flush);

    p_no_flush_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_bounded |-> !flush);

    p_isolate_enters_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_enable && core_bounded) |=> (phase_q == PH_HOLD));

endmodule

// File: rtl/ibuf_line_cell.sv
module ibuf_line_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic irq,
    input  logic capture,
    input  logic flush,
    output logic pend_q,
    output logic irq_out
);

    logic pend_d;

    always_comb begin
        if (capture)    pend_d = pend_q | irq;
        else if (flush) pend_d = 1'b0;
        else            pend_d = pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign irq_out = (irq & ~capture) | (pend_q & flush);

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && pend_q) |=> pend_q);

    p_clear_after_replay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pend_q);

    p_quiet_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !irq_out);

endmodule

// File: rtl/irq_capture_buffer.sv
module irq_capture_buffer #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] dma_trig_in,
    input  logic                 cap_enable,
    input  logic                 core_bounded,
    input  logic                 release_req,
    output logic [NUM_LINES-1:0] irq_to_core,
    output logic [NUM_LINES-1:0] dma_trig_out,
    output logic [NUM_LINES-1:0] pending_flags
);

    logic capture;
    logic flush;

    ibuf_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_enable   (cap_enable),
        .core_bounded (core_bounded),
        .release_req  (release_req),
        .any_pending  (|pending_flags),
        .capture      (capture),
        .flush        (flush)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        ibuf_line_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq     (irq_in[i]),
            .capture (capture),
            .flush   (flush),
            .pend_q  (pending_flags[i]),
            .irq_out (irq_to_core[i])
        );
    end

    assign dma_trig_out = dma_trig_in;

    p_dma_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_trig_out == dma_trig_in);

    p_pass_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_enable && !release_req) |-> (irq_to_core == irq_in));

    p_record_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_enable && core_bounded) |=> ((pending_flags & $past(irq_in)) == $past(irq_in)));

    p_no_record_unbounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_bounded && pending_flags == '0) |=> (pending_flags == '0));

endmodule

// File: tb/irq_capture_buffer_tb.sv
module irq_capture_buffer_tb;

    localparam int  N      = 5;
    localparam time CLK_PD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic [N-1:0] dma_in = '0;
    logic         en = 1'b0;
    logic         bnd = 1'b0;
    logic         rel = 1'b0;
    logic [N-1:0] irq_out;
    logic [N-1:0] dma_out;
    logic [N-1:0] pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PD/2) clk = ~clk;

    irq_capture_buffer #(.NUM_LINES(N)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_in        (irq_in),
        .dma_trig_in   (dma_in),
        .cap_enable    (en),
        .core_bounded  (bnd),
        .release_req   (rel),
        .irq_to_core   (irq_out),
        .dma_trig_out  (dma_out),
        .pending_flags (pend)
    );

    task automatic chk(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // apply inputs after a falling edge, settle, then sample
    task automatic step(input logic e, input logic b, input logic r,
                        input logic [N-1:0] i, input logic [N-1:0] d);
        @(negedge clk);
        en = e; bnd = b; rel = r; irq_in = i; dma_in = d;
        #1;
    endtask

    task automatic t_reset();
        chk("R1", "pending after reset", pend, 5'b00000);
        step(0, 0, 0, 5'b01001, 5'b00000);
        chk("R1", "pass after reset", irq_out, 5'b01001);
    endtask

    task automatic t_disabled();
        step(0, 1, 0, 5'b10101, 5'b00110);
        chk("R2", "pass while disabled and bounded", irq_out, 5'b10101);
        chk("R9", "dma while disabled", dma_out, 5'b00110);
        step(0, 1, 0, 5'b00000, 5'b00000);
        chk("R2", "nothing recorded while disabled", pend, 5'b00000);
    endtask

    task automatic t_armed();
        step(1, 0, 0, 5'b11010, 5'b00001);
        chk("R3", "pass while armed", irq_out, 5'b11010);
        step(1, 0, 0, 5'b00000, 5'b00000);
        chk("R3", "nothing recorded while armed", pend, 5'b00000);
    endtask

    task automatic t_hold_replay();
        step(1, 1, 0, 5'b00011, 5'b01010);
        chk("R4", "blocked in hold", irq_out, 5'b00000);
        chk("R9", "dma during hold", dma_out, 5'b01010);
        step(1, 1, 0, 5'b00101, 5'b10001);
        chk("R4", "blocked in hold 2", irq_out, 5'b00000);
        chk("R9", "dma during hold 2", dma_out, 5'b10001);
        step(1, 1, 1, 5'b00000, 5'b00000);
        chk("R5", "merged pending", pend, 5'b00111);
        chk("R10", "pending bit order", pend, 5'b00111);
        chk("R7", "release while bounded gives nothing", irq_out, 5'b00000);
        step(1, 0, 1, 5'b00000, 5'b00000);
        chk("R7", "pending kept after bounded release", pend, 5'b00111);
        chk("R7", "release in first unbounded cycle ignored", irq_out, 5'b00000);
        step(1, 0, 1, 5'b01000, 5'b00000);
        chk("R7", "pending kept after early release", pend, 5'b00111);
        chk("R6", "replay plus direct pulse R8", irq_out, 5'b01111);
        step(1, 0, 0, 5'b00000, 5'b00000);
        chk("R6", "pending cleared after replay", pend, 5'b00000);
        chk("R6", "replay lasts one cycle", irq_out, 5'b00000);
        chk("R8", "direct pulse not recorded", pend & 5'b01000, 5'b00000);
    endtask

    task automatic t_enable_drop();
        step(1, 1, 0, 5'b10000, 5'b00000);
        chk("R4", "blocked before drop", irq_out, 5'b00000);
        step(0, 1, 0, 5'b00010, 5'b00000);
        chk("R11", "pass after enable drop", irq_out, 5'b00010);
        chk("R11", "recorded bit kept", pend, 5'b10000);
        step(0, 0, 0, 5'b00000, 5'b00000);
        chk("R11", "no new capture after drop", pend, 5'b10000);
        step(0, 0, 1, 5'b00000, 5'b00000);
        chk("R6", "replay after enable drop", irq_out, 5'b10000);
        step(0, 0, 0, 5'b00000, 5'b00000);
        chk("R6", "cleared after second replay", pend, 5'b00000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_armed();
        t_hold_replay();
        t_enable_drop();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule